// File: doc/BRIEF.md
# Packet FIFO with Commit and Discard

This block is a word FIFO whose writer builds each packet provisionally and then decides its fate. Words enter memory as they arrive, but the reader cannot see them until the writer pulses a commit. A discard pulse rewinds the write side to the last committed point, so a packet that fails a late check, such as a trailing checksum, disappears. The reader never sees any of its words, and the next packet reuses the slots it held. Commit and discard act correctly while the reader is still draining earlier packets.

The write side keeps two pointers. A working pointer advances on every accepted word. A committed pointer moves only on commit. The reader compares its own pointer against the committed pointer, and the writer's full test compares the working pointer against the read pointer. A parameter chooses between one shared clock and two independent clocks. In the dual-clock build, the committed pointer walks one step per write clock toward its target. It travels as Gray code through two read-clock flops, and the read pointer returns to the write side the same way.

Top module: `pkt_fifo`

## Requirements
- R1: After reset, rd_empty is 1 and wr_full, wr_overflow and wr_conflict are 0.
- R2: Words written without a following commit never make rd_empty fall.
- R3: In the single-clock build, rd_empty is 0 at the first clock edge after the commit edge. Committed words are read in write order, and rd_data shows the oldest unread word while rd_empty is 0. A word accepted in the commit cycle belongs to the packet.
- R4: A discard restores the working pointer to the committed pointer. Discarded words are never presented to the reader, and the next packet's words are read in their place.
- R5: Commits and discards issued while the reader is draining an earlier packet do not disturb the words or order the reader sees.
- R6: wr_full is 1 exactly when DEPTH words, committed or not, are held unread. With DEPTH-1 words held it is 0.
- R7: A write while wr_full is 1 is ignored and sets wr_overflow. The flag stays set until the packet ends. A commit for that packet then acts as a discard, and wr_overflow clears.
- R8: Commit and discard in the same cycle act as a discard and set wr_conflict. wr_conflict stays at 1 until reset.
- R9: A read while rd_empty is 1 does not move the read pointer.
- R10: With DUAL_CLK=1, the committed pointer reaches the read domain one step per write clock as Gray code. Each step changes one bit, and each passes two read-clock flops. A commit is never visible to the reader at the first write-clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock; must be wr_clk when DUAL_CLK=0 |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en | input | 1 | Offer wr_data to the FIFO this cycle |
| wr_data | input | DW | Word to write |
| wr_commit | input | 1 | Publish all words written since the last packet end |
| wr_discard | input | 1 | Drop all words written since the last packet end |
| wr_full | output | 1 | DEPTH words unread, counted on the working pointer |
| wr_overflow | output | 1 | A write was refused in the current packet |
| wr_conflict | output | 1 | Sticky: commit and discard arrived together |
| rd_en | input | 1 | Pop the word on rd_data |
| rd_data | output | DW | Oldest committed unread word |
| rd_empty | output | 1 | No committed word is waiting |

## Verification
In the single-clock build, every write-side flag (wr_full, wr_overflow, wr_conflict) and rd_empty settles one edge after the stimulus that causes it. The bench drives on the falling edge and samples at the next falling edge, half a cycle after the only register on each path. rd_data is a combinational view of the read pointer, so the monitor compares it on the falling edge before it pops, and the pop takes effect at the next rising edge. In the dual-clock build, a commit needs up to one write cycle per word, plus one Gray register and two read flops. The bench checks that the data is not yet visible one write cycle after the commit, and that it is visible twelve read cycles later.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

  // Outcome of the current packet as decided on the write side in one cycle.
  typedef enum logic [1:0] {
    END_NONE    = 2'd0,
    END_PUBLISH = 2'd1,
    END_DROP    = 2'd2
  } pkt_end_e;

endpackage

// File: rtl/pkt_fifo_mem.sv
module pkt_fifo_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Show-ahead read: the word at the read pointer is always on the output.
  assign rdata = store[raddr];

endmodule

// File: rtl/pkt_fifo_cdc.sv
module pkt_fifo_cdc #(
  parameter int PW = 5
) (
  input  logic          src_clk,
  input  logic          src_rst_n,
  input  logic [PW-1:0] src_bin,
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  output logic [PW-1:0] dst_bin
);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] step_q, gray_q, meta_q, sync_q;
  logic          step_behind;

  // The source may jump by a whole packet; the crossing value walks one step
  // per source clock so its Gray form never changes more than one bit.
  assign step_behind = (step_q != src_bin);

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      step_q <= '0;
      gray_q <= '0;
    end else begin
      step_q <= step_q + {{(PW-1){1'b0}}, step_behind};
      gray_q <= to_gray(step_q);
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_q;
      sync_q <= meta_q;
    end
  end

  assign dst_bin = from_gray(sync_q);

  AST_GRAY_SINGLE_STEP: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R10

endmodule

// File: rtl/pkt_fifo_wrctl.sv
module pkt_fifo_wrctl
  import pkt_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          commit,
  input  logic          discard,
  input  logic [AW:0]   rptr_sync,
  output logic [AW:0]   cptr,
  output logic          full,
  output logic          overflow,
  output logic          conflict,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW{1'b0}}};

  function automatic logic at_capacity(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return (w ^ r) == DEPTH_P;
  endfunction

  logic [PW-1:0] wptr_q, cptr_q, wptr_adv;
  logic          ovf_q, err_q;
  logic          write_fire, write_blocked, pkt_ends, pkt_spoiled;
  pkt_end_e      end_act;

  assign full          = at_capacity(wptr_q, rptr_sync);
  assign write_fire    = wr_en & ~full;
  assign write_blocked = wr_en & full;
  assign pkt_ends      = commit | discard;
  assign pkt_spoiled   = ovf_q | write_blocked;
  assign wptr_adv      = wptr_q + {{AW{1'b0}}, write_fire};

  always_comb begin
    if (!pkt_ends)                                 end_act = END_NONE;
    else if (commit && !discard && !pkt_spoiled)   end_act = END_PUBLISH;
    else                                           end_act = END_DROP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      cptr_q <= '0;
      ovf_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (end_act)
        END_PUBLISH: begin
          wptr_q <= wptr_adv;
          cptr_q <= wptr_adv;
        end
        END_DROP:    wptr_q <= cptr_q;
        default:     wptr_q <= wptr_adv;
      endcase
      if (end_act != END_NONE) ovf_q <= 1'b0;
      else if (write_blocked)  ovf_q <= 1'b1;
      if (commit && discard)   err_q <= 1'b1;
    end
  end

  assign cptr      = cptr_q;
  assign overflow  = ovf_q;
  assign conflict  = err_q;
  assign mem_we    = write_fire;
  assign mem_waddr = wptr_q[AW-1:0];

  AST_HIDDEN_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cptr_q)); // R2
  AST_DISCARD_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (wptr_q == cptr_q)); // R4
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_q - rptr_sync) <= DEPTH_P); // R6
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !commit && !discard) |=> $stable(wptr_q)); // R7
  AST_OVF_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !commit && !discard) |=> overflow); // R7
  AST_OVF_PKT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && overflow) |=> ($stable(cptr_q) && !overflow)); // R7
  AST_CONFLICT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && discard) |=> ($stable(cptr_q) && conflict)); // R8
  AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> conflict); // R8

endmodule

// File: rtl/pkt_fifo_rdctl.sv
module pkt_fifo_rdctl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   cptr_sync,
  output logic [AW:0]   rptr,
  output logic          empty,
  output logic [AW-1:0] mem_raddr
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW{1'b0}}};

  logic [PW-1:0] rptr_q;
  logic          pop;

  assign empty = (rptr_q == cptr_sync);
  assign pop   = rd_en & ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rptr_q <= '0;
    else        rptr_q <= rptr_q + {{AW{1'b0}}, pop};
  end

  assign rptr      = rptr_q;
  assign mem_raddr = rptr_q[AW-1:0];

  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> $stable(rptr_q)); // R9
  AST_READ_WITHIN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cptr_sync - rptr_q) <= DEPTH_P); // R3

endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int DW       = 8,
  parameter int AW       = 4,
  parameter bit DUAL_CLK = 1'b0
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_commit,
  input  logic          wr_discard,
  output logic          wr_full,
  output logic          wr_overflow,
  output logic          wr_conflict,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);

  localparam int PW = AW + 1;

  logic [PW-1:0] cptr, cptr_rd, rptr, rptr_wr;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;

  pkt_fifo_wrctl #(.AW(AW)) u_wr (
    .clk       (wr_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .commit    (wr_commit),
    .discard   (wr_discard),
    .rptr_sync (rptr_wr),
    .cptr      (cptr),
    .full      (wr_full),
    .overflow  (wr_overflow),
    .conflict  (wr_conflict),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr)
  );

  pkt_fifo_rdctl #(.AW(AW)) u_rd (
    .clk       (rd_clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .cptr_sync (cptr_rd),
    .rptr      (rptr),
    .empty     (rd_empty),
    .mem_raddr (mem_raddr)
  );

  pkt_fifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wr_clk (wr_clk),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (wr_data),
    .raddr  (mem_raddr),
    .rdata  (rd_data)
  );

  generate
    if (DUAL_CLK) begin : g_dual
      pkt_fifo_cdc #(.PW(PW)) u_commit_xing (
        .src_clk   (wr_clk),
        .src_rst_n (rst_n),
        .src_bin   (cptr),
        .dst_clk   (rd_clk),
        .dst_rst_n (rst_n),
        .dst_bin   (cptr_rd)
      );
      pkt_fifo_cdc #(.PW(PW)) u_read_xing (
        .src_clk   (rd_clk),
        .src_rst_n (rst_n),
        .src_bin   (rptr),
        .dst_clk   (wr_clk),
        .dst_rst_n (rst_n),
        .dst_bin   (rptr_wr)
      );
    end else begin : g_single
      assign cptr_rd = cptr;
      assign rptr_wr = rptr;
    end
  endgenerate

endmodule

// File: tb/pkt_fifo_test.sv
`timescale 1ns/1ps
module pkt_fifo_test;

  logic clk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  always #4 clk  = ~clk;   // 125 MHz
  always #5 rclk = ~rclk;  // independent read clock for the dual build

  logic       wr_en = 0, wr_commit = 0, wr_discard = 0;
  logic [7:0] wr_data = 0;
  logic       wr_full, wr_overflow, wr_conflict, rd_empty;
  logic [7:0] rd_data;
  logic       mon_rd = 0, force_rd = 0, rd_en;
  assign rd_en = mon_rd | force_rd;

  pkt_fifo #(.DW(8), .AW(4), .DUAL_CLK(1'b0)) uut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .wr_commit(wr_commit), .wr_discard(wr_discard),
    .wr_full(wr_full), .wr_overflow(wr_overflow), .wr_conflict(wr_conflict),
    .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty));

  logic       d_wr_en = 0, d_commit = 0, d_rd_en = 0;
  logic [7:0] d_wdata = 0, d_rdata;
  logic       d_full, d_ovf, d_err, d_empty;

  pkt_fifo #(.DW(8), .AW(4), .DUAL_CLK(1'b1)) uut_dc (
    .wr_clk(clk), .rd_clk(rclk), .rst_n(rst_n),
    .wr_en(d_wr_en), .wr_data(d_wdata), .wr_commit(d_commit), .wr_discard(1'b0),
    .wr_full(d_full), .wr_overflow(d_ovf), .wr_conflict(d_err),
    .rd_en(d_rd_en), .rd_data(d_rdata), .rd_empty(d_empty));

  int n_chk = 0, n_fail = 0;
  logic [7:0] pend[$];
  logic [7:0] exp_q[$];
  bit    mon_on = 0;
  string mon_tag = "R3";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Driver tasks: entered on a falling edge, return on the next falling edge.
  task automatic push_word(input logic [7:0] d);
    wr_en = 1; wr_data = d; pend.push_back(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic end_commit();
    wr_commit = 1;
    foreach (pend[i]) exp_q.push_back(pend[i]);
    pend.delete();
    @(negedge clk);
    wr_commit = 0;
  endtask

  task automatic end_discard();
    wr_discard = 1; pend.delete();
    @(negedge clk);
    wr_discard = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compares the show-ahead word before popping it.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && !rd_empty) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected word visible", rd_data, -1);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(rd_data == e, mon_tag, rd_data, e);
        end
        mon_rd = 1;
      end else mon_rd = 0;
    end
  end

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_empty == 1, "R1 empty", rd_empty, 1);
    chk(wr_full == 0, "R1 full", wr_full, 0);
    chk(wr_overflow == 0, "R1 overflow", wr_overflow, 0);
    chk(wr_conflict == 0, "R1 conflict", wr_conflict, 0);

    // R2 / R3
    for (int i = 0; i < 3; i++) push_word(8'(8'h11 + i));
    repeat (2) @(negedge clk);
    chk(rd_empty == 1, "R2 uncommitted hidden", rd_empty, 1);
    end_commit();
    chk(rd_empty == 0, "R3 visible one edge after commit", rd_empty, 0);
    mon_tag = "R3 order"; mon_on = 1;
    drain();

    // R4
    for (int i = 0; i < 4; i++) push_word(8'(8'hA0 + i));
    end_discard();
    repeat (3) @(negedge clk);
    chk(rd_empty == 1, "R4 discarded hidden", rd_empty, 1);
    mon_tag = "R4 slot reuse";
    push_word(8'h21); push_word(8'h22);
    end_commit();
    drain();

    // R5: writer works while the reader drains
    mon_on = 0;
    for (int i = 0; i < 6; i++) push_word(8'(8'h30 + i));
    end_commit();
    mon_tag = "R5 concurrent"; mon_on = 1;
    for (int i = 0; i < 5; i++) push_word(8'(8'h40 + i));
    end_discard();
    for (int i = 0; i < 3; i++) push_word(8'(8'h50 + i));
    end_commit();
    drain();

    // R6 / R7
    mon_on = 0;
    for (int i = 0; i < 15; i++) push_word(8'(8'h90 + i));
    chk(wr_full == 0, "R6 not full at DEPTH-1", wr_full, 0);
    push_word(8'h9F);
    chk(wr_full == 1, "R6 full at DEPTH uncommitted", wr_full, 1);
    chk(rd_empty == 1, "R2 still hidden when full", rd_empty, 1);
    push_word(8'hEE);
    chk(wr_overflow == 1, "R7 overflow set", wr_overflow, 1);
    chk(wr_full == 1, "R7 still full", wr_full, 1);
    wr_commit = 1; pend.delete();
    @(negedge clk);
    wr_commit = 0;
    chk(rd_empty == 1, "R7 commit acted as drop", rd_empty, 1);
    chk(wr_full == 0, "R7 rewound", wr_full, 0);
    chk(wr_overflow == 0, "R7 overflow cleared", wr_overflow, 0);

    // R8
    push_word(8'h61); push_word(8'h62);
    wr_commit = 1; wr_discard = 1; pend.delete();
    @(negedge clk);
    wr_commit = 0; wr_discard = 0;
    chk(rd_empty == 1, "R8 conflict drops", rd_empty, 1);
    chk(wr_conflict == 1, "R8 flag set", wr_conflict, 1);
    push_word(8'h63);
    end_commit();
    mon_tag = "R8 after conflict"; mon_on = 1;
    drain();
    chk(wr_conflict == 1, "R8 sticky", wr_conflict, 1);

    // R9
    mon_on = 0;
    force_rd = 1;
    repeat (3) @(negedge clk);
    force_rd = 0;
    chk(rd_empty == 1, "R9 empty read", rd_empty, 1);
    push_word(8'h71); push_word(8'h72);
    end_commit();
    mon_tag = "R9 pointer unmoved"; mon_on = 1;
    drain();

    // R10: dual-clock build
    for (int i = 0; i < 3; i++) begin
      d_wr_en = 1; d_wdata = 8'(8'h81 + i);
      @(negedge clk);
    end
    d_wr_en = 0; d_commit = 1;
    @(negedge clk);
    d_commit = 0;
    chk(d_empty == 1, "R10 not yet visible", d_empty, 1);
    repeat (12) @(negedge rclk);
    chk(d_empty == 0, "R10 visible after crossing", d_empty, 0);
    for (int i = 0; i < 3; i++) begin
      chk(d_rdata == 8'(8'h81 + i), "R10 data", d_rdata, 8'h81 + i);
      d_rd_en = 1;
      @(negedge rclk);
      d_rd_en = 0;
    end
    @(negedge rclk);
    chk(d_empty == 1, "R10 drained", d_empty, 1);

    finish_up();
  end

endmodule